// File: doc/BRIEF.md
# EDO DRAM Data-Output Control Model

This block is a synthesizable, clock-sampled model of the data-pin behaviour of an extended-data-out DRAM. It holds a small array whose size is set by parameters. Testbenches of memory controllers can use it as a target whose results are easy to check. On each rising clock edge it samples the active-low row strobe, the per-byte-lane column strobes, the write strobe, the output enable, the multiplexed address and the write data. From these it decodes:

- standby,
- a normal row access (read, early write, late write or read-modify-write),
- a row-only refresh,
- a refresh started by a column strobe that falls before the row strobe.

Each byte lane has its own output latch and drive enable, and both are registered. Data is therefore visible one clock edge after the strobes that cause it. Read data stays on the pins after the column strobe rises and is released only by the conditions listed below. The model has no analog timing, no nanosecond access delays and no cell-decay behaviour.

Top module: `edo_dram_model`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls with all strobes high, `dq_oe` is 0 and `dq_out` is 0.
- R2: In an open row, lane i loads the cell at {row, column} when its column strobe is low, the write strobe is high and the lane is not in an early write. The lane drives one edge later when `out_en_n` is low. A lane whose column strobe is high does not start driving. Lane i is `dq_out[8i+7:8i]`.
- R3: A falling row strobe latches the row from `addr`, and the falling column strobe latches the column. Later address changes while the strobe stays low do not change the data that is read.
- R4: After a lane's column strobe rises with the row strobe still low, the lane keeps driving the same data.
- R5: A lane's output is released on the first edge at which both the row strobe and that lane's column strobe are sampled high.
- R6: `out_en_n` high turns the drivers off without changing the latched data. When `out_en_n` returns low, the same data is driven again.
- R7: Early write: when a column strobe falls with the write strobe low in an open row, `din` is written at {row, column}, only in the lanes whose column strobe is low. No lane drives during the cycle.
- R8: Late write: when the write strobe falls while a lane's column strobe is low in an open row, `din` sampled at that edge is written at the latched column. The lane stops driving. Later `din` changes while the write strobe stays low are not written.
- R9: Read-modify-write: data read in a cycle is the value from before the write, and a later read returns the written value.
- R10: A row strobe fall with all column strobes high opens a row only. With no column strobe, nothing is driven and no cell changes, even with the write strobe low.
- R11: A row strobe fall with any column strobe low is a refresh. It writes nothing, and lanes that were driving before keep driving the same data (hidden refresh).
- R12: Column strobes toggling while the row strobe is high write nothing and start no driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | LANES | Per-lane column strobes, active low |
| write_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| din | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Latched read data |
| dq_oe | output | LANES | Per-lane drive enable |

## Verification
The hardest case to reach is the hidden refresh. A read must be left driving, the row strobe raised while the column strobes stay low, and the row strobe then dropped again, so that the decoder sees a column-first refresh with the output latch still full. The bench builds this sequence in single steps and also toggles the write strobe and data during the refresh. It then reads the cells back to confirm that nothing was written. Before this, the bench fills and reads back the whole array in page mode, which gives every later scenario a known shadow image to compare against.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_ROW  = 2'd1,
      CYC_CBR  = 2'd2
   } cyc_e;
endpackage

// File: rtl/edo_strobe_decode.sv
module edo_strobe_decode
   import edo_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3,
   parameter int LANES = 2,
   parameter int AW    = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             row_strobe_n,
   input  logic [LANES-1:0] col_strobe_n,
   input  logic             write_n,
   input  logic [AW-1:0]    addr,
   output logic             row_open,
   output logic [LANES-1:0] cas_fall,
   output logic             we_fall,
   output logic [ROW_W-1:0] row_idx,
   output logic [COL_W-1:0] col_idx
);
   logic             ras_q, we_q;
   logic [LANES-1:0] cas_q;
   cyc_e             cyc_q, cyc_now;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             ras_fall;

   always_comb begin
      ras_fall = ras_q & ~row_strobe_n;
      cas_fall = cas_q & ~col_strobe_n;
      we_fall  = we_q & ~write_n;
      if (row_strobe_n)
         cyc_now = CYC_IDLE;
      else if (ras_fall)
         cyc_now = (&col_strobe_n) ? CYC_ROW : CYC_CBR;
      else
         cyc_now = cyc_q;
      row_open = (cyc_now == CYC_ROW);
      row_idx  = ras_fall ? addr[ROW_W-1:0] : row_q;
      col_idx  = (|cas_fall) ? addr[COL_W-1:0] : col_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ras_q <= 1'b1;
         cas_q <= '1;
         we_q  <= 1'b1;
         cyc_q <= CYC_IDLE;
         row_q <= '0;
         col_q <= '0;
      end else begin
         ras_q <= row_strobe_n;
         cas_q <= col_strobe_n;
         we_q  <= write_n;
         cyc_q <= cyc_now;
         row_q <= row_idx;
         col_q <= col_idx;
      end
   end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
   parameter int ROW_W  = 3,
   parameter int COL_W  = 3,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        wr_en,
   input  logic [ROW_W-1:0]        row,
   input  logic [COL_W-1:0]        col,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int IW    = ROW_W + COL_W;
   localparam int DEPTH = 1 << IW;

   logic [IW-1:0] idx;
   assign idx = {row, col};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en[l])
            cells[idx] <= wdata[l*LANE_W +: LANE_W];
      end
      assign rdata[l*LANE_W +: LANE_W] = cells[idx];
   end
endmodule

// File: rtl/edo_lane_out.sv
module edo_lane_out #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              row_open,
   input  logic              ras_high,
   input  logic              cas_n,
   input  logic              cas_fell,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [LANE_W-1:0] rdata,
   output logic              drv,
   output logic [LANE_W-1:0] data
);
   logic valid_q, early_q, valid_d, early_d, load, wr_hit;

   always_comb begin
      if (cas_n)
         early_d = 1'b0;
      else if (cas_fell && row_open && !we_n)
         early_d = 1'b1;
      else
         early_d = early_q;
      load   = row_open & ~cas_n & we_n & ~early_d;
      wr_hit = row_open & ~cas_n & ~we_n;
      if (load)
         valid_d = 1'b1;
      else if (wr_hit)
         valid_d = 1'b0;
      else if (ras_high && cas_n)
         valid_d = 1'b0;
      else
         valid_d = valid_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         early_q <= 1'b0;
         drv     <= 1'b0;
         data    <= '0;
      end else begin
         valid_q <= valid_d;
         early_q <= early_d;
         drv     <= valid_d & ~oe_n;
         if (load)
            data <= rdata;
      end
   end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
   parameter int ROW_W  = 3,
   parameter int COL_W  = 3,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             row_strobe_n,
   input  logic [LANES-1:0] col_strobe_n,
   input  logic             write_n,
   input  logic             out_en_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dq_out,
   output logic [LANES-1:0] dq_oe
);
   initial begin
      assert (ROW_W >= 1 && ROW_W <= 10) else $error("ROW_W out of range");
      assert (COL_W >= 1 && COL_W <= 10) else $error("COL_W out of range");
      assert (LANES >= 1 && LANE_W >= 1) else $error("lane shape invalid");
   end

   logic             row_open, we_fall;
   logic [LANES-1:0] cas_fall, wr_en;
   logic [ROW_W-1:0] row_idx;
   logic [COL_W-1:0] col_idx;
   logic [DW-1:0]    rdata;

   edo_strobe_decode #(
      .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .AW(AW)
   ) u_dec (
      .clk(clk), .rst(rst), .row_strobe_n(row_strobe_n),
      .col_strobe_n(col_strobe_n), .write_n(write_n), .addr(addr),
      .row_open(row_open), .cas_fall(cas_fall), .we_fall(we_fall),
      .row_idx(row_idx), .col_idx(col_idx)
   );

   always_comb begin
      for (int l = 0; l < LANES; l++)
         wr_en[l] = row_open & ~col_strobe_n[l] & ~write_n & (cas_fall[l] | we_fall);
   end

   edo_cell_array #(
      .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .LANE_W(LANE_W)
   ) u_arr (
      .clk(clk), .wr_en(wr_en), .row(row_idx), .col(col_idx),
      .wdata(din), .rdata(rdata)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_out
      edo_lane_out #(.LANE_W(LANE_W)) u_lane (
         .clk(clk), .rst(rst), .row_open(row_open), .ras_high(row_strobe_n),
         .cas_n(col_strobe_n[l]), .cas_fell(cas_fall[l]), .we_n(write_n),
         .oe_n(out_en_n), .rdata(rdata[l*LANE_W +: LANE_W]),
         .drv(dq_oe[l]), .data(dq_out[l*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/edo_dram_model_chk.sv
module edo_dram_model_chk #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    row_strobe_n,
   input logic [LANES-1:0]        col_strobe_n,
   input logic                    write_n,
   input logic                    out_en_n,
   input logic                    row_open,
   input logic [LANES*LANE_W-1:0] dq_out,
   input logic [LANES-1:0]        dq_oe
);
   AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
      (dq_oe != '0) |-> $past(!out_en_n)); // R6

   AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
      (row_strobe_n && (&col_strobe_n)) |=> (dq_oe == '0)); // R5

   AST_NO_START_ROW_HIGH: assert property (@(posedge clk) disable iff (rst)
      ((dq_oe == '0) && $past(!out_en_n) && row_strobe_n) |=> (dq_oe == '0)); // R12

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
         (row_open && !write_n && !col_strobe_n[l]) |=> !dq_oe[l]); // R7

      AST_EDO_HOLD: assert property (@(posedge clk) disable iff (rst)
         (!row_strobe_n && dq_oe[l] && col_strobe_n[l] && !out_en_n)
         |=> (dq_oe[l] && $stable(dq_out[l*LANE_W +: LANE_W]))); // R4
   end
endmodule

bind edo_dram_model edo_dram_model_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst(rst), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
   .write_n(write_n), .out_en_n(out_en_n), .row_open(row_open),
   .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/edo_dram_model_test.sv
module edo_dram_model_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ras_n = 1'b1;
   logic [1:0]  cas_n = 2'b11;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic [2:0]  addr = '0;
   logic [15:0] din = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;

   int total = 0;
   int failed = 0;
   bit done = 0;
   logic [15:0] shadow [64];

   always #5 clk = ~clk;

   edo_dram_model uut (
      .clk(clk), .rst(rst), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
      .write_n(we_n), .out_en_n(oe_n), .addr(addr), .din(din),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic logic [15:0] pat(int r, int c);
      return 16'((r * 4919 + c * 2833 + 9029) & 16'hFFFF);
   endfunction

   task automatic drive(input logic r, input logic [1:0] c, input logic w,
                        input logic o, input logic [2:0] a, input logic [15:0] d);
      ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [1:0] eoe, input logic [15:0] ed);
      logic [15:0] mask;
      mask = {{8{eoe[1]}}, {8{eoe[0]}}};
      total++;
      if (dq_oe !== eoe || ((dq_out ^ ed) & mask) !== 16'h0) begin
         failed++;
         $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", tag, dq_oe, dq_out, eoe, ed);
      end
   endtask

   task automatic open_row(input logic [2:0] r);
      drive(1'b0, 2'b11, 1'b1, 1'b1, r, 16'h0);
   endtask

   task automatic close_row();
      drive(1'b0, 2'b11, 1'b1, 1'b1, 3'd0, 16'h0);
      drive(1'b1, 2'b11, 1'b1, 1'b1, 3'd0, 16'h0);
   endtask

   task automatic readback(input string tag, input int r, input int c);
      open_row(3'(r));
      drive(1'b0, 2'b00, 1'b1, 1'b0, 3'(c), 16'h0);
      chk(tag, 2'b11, shadow[r*8+c]);
      close_row();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      failed++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      chk("R1 in reset", 2'b00, 16'h0);
      total++;
      if (dq_out !== 16'h0) begin
         failed++;
         $display("FAIL R1 data: actual=%h expected=0000", dq_out);
      end
      @(negedge clk);
      rst = 1'b0;
      drive(1'b1, 2'b11, 1'b1, 1'b0, 3'd0, 16'h0);
      chk("R1 after reset", 2'b00, 16'h0);

      // Fill the whole array with early writes (R7)
      for (int r = 0; r < 8; r++) begin
         open_row(3'(r));
         for (int c = 0; c < 8; c++) begin
            drive(1'b0, 2'b00, 1'b0, 1'b0, 3'(c), pat(r, c));
            chk("R7 early write quiet", 2'b00, 16'h0);
            shadow[r*8+c] = pat(r, c);
            drive(1'b0, 2'b11, 1'b1, 1'b0, 3'(c), 16'h0);
         end
         close_row();
      end

      // Page-mode read sweep: R2, R4, R5
      for (int r = 0; r < 8; r++) begin
         open_row(3'(r));
         for (int c = 0; c < 8; c++) begin
            drive(1'b0, 2'b00, 1'b1, 1'b0, 3'(c), 16'h0);
            chk("R2 page read", 2'b11, shadow[r*8+c]);
            drive(1'b0, 2'b11, 1'b1, 1'b0, 3'((c + 1) % 8), 16'h0);
            chk("R4 hold after column rise", 2'b11, shadow[r*8+c]);
         end
         drive(1'b1, 2'b11, 1'b1, 1'b0, 3'd0, 16'h0);
         chk("R5 release at idle", 2'b00, 16'h0);
      end

      // R3 column latched at strobe fall
      open_row(3'd1);
      drive(1'b0, 2'b00, 1'b1, 1'b0, 3'd2, 16'h0);
      chk("R3 first read", 2'b11, shadow[1*8+2]);
      drive(1'b0, 2'b00, 1'b1, 1'b0, 3'd5, 16'h0);
      chk("R3 address moved while low", 2'b11, shadow[1*8+2]);
      close_row();
      chk("R5 after close", 2'b00, 16'h0);

      // R2 single lane
      open_row(3'd2);
      drive(1'b0, 2'b10, 1'b1, 1'b0, 3'd3, 16'h0);
      chk("R2 lower lane only", 2'b01, shadow[2*8+3]);
      drive(1'b0, 2'b01, 1'b1, 1'b0, 3'd3, 16'h0);
      chk("R2 upper joins, lower held", 2'b11, shadow[2*8+3]);
      close_row();

      // R6 output enable
      open_row(3'd3);
      drive(1'b0, 2'b00, 1'b1, 1'b0, 3'd4, 16'h0);
      chk("R6 read", 2'b11, shadow[3*8+4]);
      drive(1'b0, 2'b11, 1'b1, 1'b0, 3'd4, 16'h0);
      drive(1'b0, 2'b11, 1'b1, 1'b1, 3'd6, 16'h0);
      chk("R6 oe high off", 2'b00, 16'h0);
      drive(1'b0, 2'b11, 1'b1, 1'b0, 3'd6, 16'h0);
      chk("R6 oe low same data", 2'b11, shadow[3*8+4]);
      close_row();

      // R7 byte-lane early write
      open_row(3'd2);
      drive(1'b0, 2'b10, 1'b0, 1'b1, 3'd5, 16'hA55A);
      chk("R7 lane write quiet", 2'b00, 16'h0);
      shadow[2*8+5][7:0] = 8'h5A;
      drive(1'b0, 2'b11, 1'b1, 1'b1, 3'd5, 16'h0);
      close_row();
      readback("R7 lower lane only written", 2, 5);

      // R8 late write
      open_row(3'd3);
      drive(1'b0, 2'b00, 1'b1, 1'b1, 3'd1, 16'h0);
      chk("R8 read with oe high", 2'b00, 16'h0);
      drive(1'b0, 2'b00, 1'b0, 1'b1, 3'd1, 16'hC3E1);
      shadow[3*8+1] = 16'hC3E1;
      drive(1'b0, 2'b00, 1'b0, 1'b1, 3'd1, 16'h1111);
      chk("R8 late write quiet", 2'b00, 16'h0);
      drive(1'b0, 2'b11, 1'b1, 1'b1, 3'd1, 16'h0);
      close_row();
      readback("R8 late write data", 3, 1);

      // R9 read-modify-write
      open_row(3'd4);
      drive(1'b0, 2'b00, 1'b1, 1'b0, 3'd6, 16'h0);
      chk("R9 old data read", 2'b11, shadow[4*8+6]);
      drive(1'b0, 2'b00, 1'b1, 1'b1, 3'd6, 16'h0);
      drive(1'b0, 2'b00, 1'b0, 1'b1, 3'd6, 16'h3C96);
      chk("R9 write quiet", 2'b00, 16'h0);
      shadow[4*8+6] = 16'h3C96;
      drive(1'b0, 2'b11, 1'b1, 1'b1, 3'd6, 16'h0);
      close_row();
      readback("R9 modified data", 4, 6);

      // R10 row-only refresh
      drive(1'b0, 2'b11, 1'b0, 1'b0, 3'd5, 16'hFFFF);
      chk("R10 no drive", 2'b00, 16'h0);
      drive(1'b0, 2'b11, 1'b0, 1'b0, 3'd5, 16'hFFFF);
      chk("R10 still no drive", 2'b00, 16'h0);
      drive(1'b1, 2'b11, 1'b1, 1'b1, 3'd0, 16'h0);
      for (int c = 0; c < 8; c++) readback("R10 row unchanged", 5, c);

      // R11 hidden refresh
      open_row(3'd6);
      drive(1'b0, 2'b00, 1'b1, 1'b0, 3'd2, 16'h0);
      chk("R11 read", 2'b11, shadow[6*8+2]);
      drive(1'b1, 2'b00, 1'b1, 1'b0, 3'd2, 16'h0);
      chk("R11 row strobe high, column low", 2'b11, shadow[6*8+2]);
      drive(1'b0, 2'b00, 1'b0, 1'b0, 3'd7, 16'hDEAD);
      chk("R11 refresh keeps data", 2'b11, shadow[6*8+2]);
      drive(1'b0, 2'b00, 1'b0, 1'b0, 3'd7, 16'hBEEF);
      chk("R11 refresh with write low", 2'b11, shadow[6*8+2]);
      drive(1'b1, 2'b00, 1'b1, 1'b0, 3'd7, 16'h0);
      chk("R11 refresh end", 2'b11, shadow[6*8+2]);
      drive(1'b1, 2'b11, 1'b1, 1'b0, 3'd7, 16'h0);
      chk("R5 release after refresh", 2'b00, 16'h0);
      readback("R11 cell unchanged col2", 6, 2);
      readback("R11 cell unchanged col7", 6, 7);

      // R12 column strobes with row strobe high
      drive(1'b1, 2'b00, 1'b0, 1'b0, 3'd3, 16'h7777);
      chk("R12 column-only write", 2'b00, 16'h0);
      drive(1'b1, 2'b11, 1'b1, 1'b0, 3'd3, 16'h0);
      drive(1'b1, 2'b00, 1'b1, 1'b0, 3'd3, 16'h0);
      chk("R12 column-only read", 2'b00, 16'h0);
      drive(1'b1, 2'b11, 1'b1, 1'b0, 3'd3, 16'h0);
      for (int r = 0; r < 8; r++) readback("R12 no cell written", r, 3);

      finish_run();
   end
endmodule